// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block collects a parameterised number of system interrupt inputs (a multiple of 32, default 64) and drives one host interrupt line. Each input has its own detection mode, chosen by a polarity bit and a type bit. Detection sets a sticky status bit, and a per-source enable decides whether that status counts as pending. Every source is assigned an 8-bit priority channel. A global enable and a host-line enable both gate the output line.

Software reaches the controller through a single-cycle bus with byte addresses. Writes take effect on the clock edge, and reads return data combinationally in the same cycle. One source can be handled by writing its number to an index register, which sets an enable, clears an enable or clears a status bit. Many sources can be handled at once through 32-bit bitmap words. One read of the prioritized index register returns the winning pending source, so a handler needs no scan.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset every register reads 0, `host_irq` is 0, and the prioritized index register (0x80) reads 0x8000_0000.
- R2: Level detection uses {type,polarity} = 00 for active-low and 01 for active-high. While the input is active, status is set again on every clock. When a status clear and a detection land on the same edge, the detection wins.
- R3: Edge detection uses {type,polarity} = 11 for rising and 10 for falling. The input is compared with its value one clock earlier. A detected edge sets status, and the status stays set after the input returns. Holding the input steady sets nothing further.
- R4: Writing N to 0x24 clears the status of source N and of no other source.
- R5: Writing N to 0x28 sets the enable of source N, and writing N to 0x2C clears it. Any N ≥ NSRC is ignored. Word w of the enables reads back at 0x380+4w.
- R6: Writing to 0x280+4w clears the status bits of sources 32w+b wherever data bit b is 1, and word w of the status reads back there. Writing to 0x380+4w clears enable bits in the same way. Polarity words sit at 0xD00+4w and type words at 0xD80+4w, and both are read/write.
- R7: The channel map word at 0x400+4w holds the channel of source 4w+k in byte k, and reads back as written.
- R8: Reading 0x80 returns, in bits 9:0, the enabled source with status set that has the lowest channel number. A tie goes to the lower source number. When no enabled source has status set, the read returns 0x8000_0000 (bit 31 set, index 0).
- R9: Bit 0 of 0x10 is the global enable. While it is 0, `host_irq` stays 0, but status still latches.
- R10: Writing 0 to 0x34 sets the enable of host line 0, and writing 0 to 0x38 clears it. Any other line number written to either register is ignored.
- R11: `host_irq` equals the value of (any enabled status set) AND global enable AND host-line-0 enable as it stood one clock earlier.
- R12: The control registers at 0x04 and 0x0C store a full 32-bit word and read it back. The value 0 selects normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | System interrupt inputs |
| bus_we | input | 1 | Write strobe, applied on the clock edge |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| host_irq | output | 1 | Registered host interrupt line 0 |

## Verification
Two situations are hard to reach from the ports. The first is a status clear that lands on the same edge as a detection. The bench produces it by writing a source number to the index-clear register while that level input is still held active. It does the same with an edge input that is held high, where the clear must stick. The second is a pair of enabled sources that tie on priority. The bench reaches it by reprogramming one channel-map byte so that two enabled sources share a channel, and it checks that the lower source number wins. A behavioural model compares every read and the host line on every clock throughout.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int ADDR_W = 13;
    localparam int IDX_W  = 10;
    localparam int CH_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL      = 13'h004;
    localparam logic [ADDR_W-1:0] OFS_HCTRL     = 13'h00c;
    localparam logic [ADDR_W-1:0] OFS_GEN       = 13'h010;
    localparam logic [ADDR_W-1:0] OFS_ST_IDXCLR = 13'h024;
    localparam logic [ADDR_W-1:0] OFS_EN_IDXSET = 13'h028;
    localparam logic [ADDR_W-1:0] OFS_EN_IDXCLR = 13'h02c;
    localparam logic [ADDR_W-1:0] OFS_HEN_SET   = 13'h034;
    localparam logic [ADDR_W-1:0] OFS_HEN_CLR   = 13'h038;
    localparam logic [ADDR_W-1:0] OFS_PRIO      = 13'h080;
    localparam logic [ADDR_W-1:0] BASE_STCLR    = 13'h280;
    localparam logic [ADDR_W-1:0] BASE_ENCLR    = 13'h380;
    localparam logic [ADDR_W-1:0] BASE_CMAP     = 13'h400;
    localparam logic [ADDR_W-1:0] BASE_POL      = 13'hd00;
    localparam logic [ADDR_W-1:0] BASE_TYPE     = 13'hd80;

    // detection mode, encoded as {type, polarity}
    typedef enum logic [1:0] {
        DET_LVL_LO = 2'b00,
        DET_LVL_HI = 2'b01,
        DET_FALL   = 2'b10,
        DET_RISE   = 2'b11
    } det_mode_t;

    typedef struct packed {
        logic             none;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int w);
        return base + ADDR_W'(4 * w);
    endfunction
endpackage

// File: rtl/intc_detect.sv
module intc_detect
    import intc_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] typ_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] src_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_comb begin
            case (det_mode_t'({typ_i[i], pol_i[i]}))
                DET_LVL_LO: hit[i] = ~src_i[i];
                DET_LVL_HI: hit[i] = src_i[i];
                DET_FALL:   hit[i] = ~src_i[i] & src_q[i];
                default:    hit[i] = src_i[i] & ~src_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            stat_o <= '0;
        end else begin
            src_q  <= src_i;
            stat_o <= (stat_o & ~clr_i) | hit;
        end
    end

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_o & $past(clr_i & ~hit)) == '0)); // R4
    AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_o & $past(hit)) == $past(hit))); // R2
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0]      pend_i,
    input  logic [N*CH_W-1:0] chan_i,
    output win_t              win_o
);
    always_comb begin
        logic            found;
        logic [CH_W-1:0] best;
        found = 1'b0;
        best  = '0;
        win_o = '{none: 1'b1, idx: '0};
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && (!found || chan_i[i*CH_W +: CH_W] < best)) begin
                found     = 1'b1;
                best      = chan_i[i*CH_W +: CH_W];
                win_o.idx = IDX_W'(i);
            end
        end
        win_o.none = ~found;
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              host_irq
);
    localparam int NW  = NSRC / 32;
    localparam int NCM = NSRC / 4;
    localparam int SW  = $clog2(NSRC);

    logic [31:0]          ctrl_q, hctrl_q;
    logic                 gen_q, hen_q;
    logic [NSRC-1:0]      en_q, pol_q, typ_q, clr, stat, pend;
    logic [NSRC*CH_W-1:0] cmap_q;
    win_t                 win;
    logic                 idx_ok;
    logic [SW-1:0]        wsel;

    assign idx_ok = bus_wdata < 32'(NSRC);
    assign wsel   = bus_wdata[SW-1:0];
    assign pend   = stat & en_q;

    always_comb begin
        clr = '0;
        if (bus_we && bus_addr == OFS_ST_IDXCLR && idx_ok) clr[wsel] = 1'b1;
        for (int w = 0; w < NW; w++)
            if (bus_we && bus_addr == word_addr(BASE_STCLR, w)) clr[w*32 +: 32] = bus_wdata;
    end

    intc_detect #(.N(NSRC)) u_det (
        .clk(clk), .rst(rst), .src_i(src_in), .pol_i(pol_q), .typ_i(typ_q),
        .clr_i(clr), .stat_o(stat)
    );

    intc_arbiter #(.N(NSRC)) u_arb (
        .pend_i(pend), .chan_i(cmap_q), .win_o(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            hctrl_q <= '0;
            gen_q   <= 1'b0;
            hen_q   <= 1'b0;
            en_q    <= '0;
            pol_q   <= '0;
            typ_q   <= '0;
            cmap_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_CTRL)  ctrl_q  <= bus_wdata;
            if (bus_addr == OFS_HCTRL) hctrl_q <= bus_wdata;
            if (bus_addr == OFS_GEN)   gen_q   <= bus_wdata[0];
            if (bus_addr == OFS_HEN_SET && bus_wdata == 32'd0) hen_q <= 1'b1;
            if (bus_addr == OFS_HEN_CLR && bus_wdata == 32'd0) hen_q <= 1'b0;
            if (bus_addr == OFS_EN_IDXSET && idx_ok) en_q[wsel] <= 1'b1;
            if (bus_addr == OFS_EN_IDXCLR && idx_ok) en_q[wsel] <= 1'b0;
            for (int w = 0; w < NW; w++) begin
                if (bus_addr == word_addr(BASE_ENCLR, w))
                    en_q[w*32 +: 32] <= en_q[w*32 +: 32] & ~bus_wdata;
                if (bus_addr == word_addr(BASE_POL, w))  pol_q[w*32 +: 32] <= bus_wdata;
                if (bus_addr == word_addr(BASE_TYPE, w)) typ_q[w*32 +: 32] <= bus_wdata;
            end
            for (int c = 0; c < NCM; c++)
                if (bus_addr == word_addr(BASE_CMAP, c)) cmap_q[c*32 +: 32] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) host_irq <= 1'b0;
        else     host_irq <= (|pend) & gen_q & hen_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_q;
            OFS_HCTRL: bus_rdata = hctrl_q;
            OFS_GEN:   bus_rdata = {31'd0, gen_q};
            OFS_PRIO:  bus_rdata = {win.none, {(31-IDX_W){1'b0}}, win.idx};
            default:   bus_rdata = '0;
        endcase
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == word_addr(BASE_STCLR, w)) bus_rdata = stat[w*32 +: 32];
            if (bus_addr == word_addr(BASE_ENCLR, w)) bus_rdata = en_q[w*32 +: 32];
            if (bus_addr == word_addr(BASE_POL, w))   bus_rdata = pol_q[w*32 +: 32];
            if (bus_addr == word_addr(BASE_TYPE, w))  bus_rdata = typ_q[w*32 +: 32];
        end
        for (int c = 0; c < NCM; c++)
            if (bus_addr == word_addr(BASE_CMAP, c)) bus_rdata = cmap_q[c*32 +: 32];
    end

    initial assert (NSRC % 32 == 0 && NSRC <= 1024);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !host_irq); // R1
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        !gen_q |=> !host_irq); // R9
    AST_HOST_GATE: assert property (@(posedge clk) disable iff (rst)
        !hen_q |=> !host_irq); // R10
    AST_NONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> !win.none); // R8
    AST_WINNER_PENDS: assert property (@(posedge clk) disable iff (rst)
        !win.none |-> pend[win.idx[SW-1:0]]); // R8
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    localparam int N  = 64;
    localparam int NW = N / 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src = '0;
    logic          we = 1'b0;
    logic [12:0]   addr = '0;
    logic [31:0]   wd = '0;
    logic [31:0]   rd;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prio_intc #(.NSRC(N)) u0 (
        .clk(clk), .rst(rst), .src_in(src), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rd), .host_irq(irq)
    );

    // behavioural reference model
    logic [N-1:0] m_stat, m_en, m_pol, m_typ, m_q;
    logic [7:0]   m_ch [N];
    logic [31:0]  m_ctrl, m_hctrl;
    logic         m_gen, m_hen, m_irq;

    function automatic logic [31:0] m_read(input logic [12:0] a);
        int best, bidx;
        if (a == 13'h004) return m_ctrl;
        if (a == 13'h00c) return m_hctrl;
        if (a == 13'h010) return {31'd0, m_gen};
        if (a == 13'h080) begin
            best = 999; bidx = -1;
            for (int i = 0; i < N; i++)
                if (m_stat[i] && m_en[i] && int'(m_ch[i]) < best) begin
                    best = int'(m_ch[i]); bidx = i;
                end
            if (bidx < 0) return 32'h8000_0000;
            return 32'(bidx);
        end
        for (int w = 0; w < NW; w++) begin
            if (a == 13'(32'h280 + 4*w)) return m_stat[w*32 +: 32];
            if (a == 13'(32'h380 + 4*w)) return m_en[w*32 +: 32];
            if (a == 13'(32'hd00 + 4*w)) return m_pol[w*32 +: 32];
            if (a == 13'(32'hd80 + 4*w)) return m_typ[w*32 +: 32];
        end
        for (int c = 0; c < N/4; c++)
            if (a == 13'(32'h400 + 4*c))
                return {m_ch[4*c+3], m_ch[4*c+2], m_ch[4*c+1], m_ch[4*c]};
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [12:0] a);
        if (a == 13'h080) return "R8";
        if (a < 13'h020) return "R12";
        if (a >= 13'h280 && a < 13'h300) return "R4";
        if (a >= 13'h380 && a < 13'h400) return "R5";
        if (a >= 13'h400 && a < 13'h500) return "R7";
        return "R6";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [N-1:0] hit, clr;
        logic nirq;
        if (rst) begin
            m_stat = '0; m_en = '0; m_pol = '0; m_typ = '0; m_q = '0;
            m_ctrl = '0; m_hctrl = '0; m_gen = 1'b0; m_hen = 1'b0; m_irq = 1'b0;
            for (int i = 0; i < N; i++) m_ch[i] = 8'd0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_typ[i]) hit[i] = m_pol[i] ? (src[i] && !m_q[i]) : (!src[i] && m_q[i]);
                else          hit[i] = m_pol[i] ? src[i] : !src[i];
            end
            clr = '0;
            if (we && addr == 13'h024 && wd < N) clr[wd] = 1'b1;
            for (int w = 0; w < NW; w++)
                if (we && addr == 13'(32'h280 + 4*w)) clr[w*32 +: 32] = wd;
            nirq = ((m_stat & m_en) != '0) && m_gen && m_hen;
            m_stat = (m_stat & ~clr) | hit;
            if (we) begin
                if (addr == 13'h004) m_ctrl = wd;
                if (addr == 13'h00c) m_hctrl = wd;
                if (addr == 13'h010) m_gen = wd[0];
                if (addr == 13'h034 && wd == 0) m_hen = 1'b1;
                if (addr == 13'h038 && wd == 0) m_hen = 1'b0;
                if (addr == 13'h028 && wd < N) m_en[wd] = 1'b1;
                if (addr == 13'h02c && wd < N) m_en[wd] = 1'b0;
                for (int w = 0; w < NW; w++) begin
                    if (addr == 13'(32'h380 + 4*w)) m_en[w*32 +: 32] = m_en[w*32 +: 32] & ~wd;
                    if (addr == 13'(32'hd00 + 4*w)) m_pol[w*32 +: 32] = wd;
                    if (addr == 13'(32'hd80 + 4*w)) m_typ[w*32 +: 32] = wd;
                end
                for (int c = 0; c < N/4; c++)
                    if (addr == 13'(32'h400 + 4*c))
                        for (int k = 0; k < 4; k++) m_ch[4*c+k] = wd[8*k +: 8];
            end
            m_q = src;
            m_irq = nirq;
        end
        #2;
        chk("R11", {31'd0, irq}, {31'd0, m_irq});
        chk(tag_of(addr), rd, m_read(addr));
    end

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wd = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rdchk(input logic [12:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); addr = a; #1;
        chk(tag, rd, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rdchk(13'h080, 32'h8000_0000, "R1");
        chk("R1", {31'd0, irq}, 32'd0);
        rdchk(13'h380, 32'd0, "R1");
        @(negedge clk); rst = 1'b0;
        idle(2);
        rdchk(13'h280, 32'hffff_ffff, "R2");          // level-low with inputs low
        wr(13'hd00, 32'hffff_ffff);
        wr(13'hd04, 32'hffff_ffff);
        wr(13'h280, 32'hffff_ffff);
        wr(13'h284, 32'hffff_ffff);
        rdchk(13'h280, 32'd0, "R6");
        rdchk(13'h284, 32'd0, "R6");
        wr(13'h028, 32'd3);
        wr(13'h028, 32'd200);
        rdchk(13'h380, 32'h8, "R5");
        rdchk(13'h384, 32'd0, "R5");
        wr(13'h034, 32'd0);
        src[3] = 1'b1;
        idle(3);
        chk("R9", {31'd0, irq}, 32'd0);
        rdchk(13'h280, 32'h8, "R9");
        rdchk(13'h080, 32'd3, "R8");
        wr(13'h010, 32'd1);
        chk("R11", {31'd0, irq}, 32'd0);
        idle(1);
        chk("R11", {31'd0, irq}, 32'd1);
        wr(13'h024, 32'd3);                           // clear while level active
        rdchk(13'h280, 32'h8, "R2");
        src[3] = 1'b0; src[7] = 1'b1;
        idle(2);
        src[7] = 1'b0;
        wr(13'h024, 32'd3);
        rdchk(13'h280, 32'h80, "R4");
        wr(13'hd80, 32'h400);                         // source 10 rising
        src[10] = 1'b1; idle(1); src[10] = 1'b0; idle(2);
        rdchk(13'h280, 32'h480, "R3");
        src[10] = 1'b1; idle(2);
        wr(13'h024, 32'd10);
        idle(2);
        rdchk(13'h280, 32'h80, "R3");
        src[10] = 1'b0;
        wr(13'hd84, 32'h100);                         // source 40 edge
        wr(13'hd04, ~32'h100);                        // then falling
        src[40] = 1'b1; idle(2);
        rdchk(13'h284, 32'd0, "R3");
        src[40] = 1'b0; idle(2);
        rdchk(13'h284, 32'h100, "R3");
        wr(13'h408, 32'h0102_0304);
        rdchk(13'h408, 32'h0102_0304, "R7");
        wr(13'h028, 32'd10);
        wr(13'h028, 32'd40);
        src[10] = 1'b1; idle(1); src[10] = 1'b0; idle(1);
        rdchk(13'h080, 32'd40, "R8");
        wr(13'h428, 32'd5);
        rdchk(13'h080, 32'd10, "R8");
        wr(13'h400, 32'h0200_0000);
        src[3] = 1'b1; idle(2); src[3] = 1'b0;
        rdchk(13'h080, 32'd3, "R8");                  // tie on channel 2
        wr(13'h038, 32'd1);
        chk("R10", {31'd0, irq}, 32'd1);
        wr(13'h038, 32'd0); idle(1);
        chk("R10", {31'd0, irq}, 32'd0);
        wr(13'h034, 32'd5); idle(1);
        chk("R10", {31'd0, irq}, 32'd0);
        wr(13'h034, 32'd0); idle(1);
        chk("R10", {31'd0, irq}, 32'd1);
        wr(13'h010, 32'd0); idle(1);
        chk("R9", {31'd0, irq}, 32'd0);
        wr(13'h380, 32'h8);
        rdchk(13'h380, 32'h400, "R6");
        wr(13'h02c, 32'd10);
        rdchk(13'h380, 32'd0, "R5");
        wr(13'h004, 32'h55);
        wr(13'h00c, 32'ha5);
        rdchk(13'h004, 32'h55, "R12");
        rdchk(13'h00c, 32'ha5, "R12");
        rdchk(13'h080, 32'd40, "R8");
        wr(13'h284, 32'h100);
        rdchk(13'h080, 32'h8000_0000, "R8");
        idle(2);
        summary();
    end
endmodule